// File: doc/BRIEF.md
# Wake-Up Alarm Timer

A small register-mapped up-counter used as a one-shot wake-up alarm. Software programs a reload value and a terminal value, picks a prescaler divide and turns the count on. The counter then advances on a slow external tick input. When it has spent one step at the terminal value, it reloads, raises a sticky overflow flag and, if enabled, drives a level interrupt until software clears the flag.

The block sits on a plain 32-bit register bus. Writes are single-cycle strobes and reads return data combinationally from the address. The tick input is asynchronous to the bus clock. It is synchronized and edge-detected, so each rising edge of the tick counts as one raw tick. The counter is 16 bits wide.

Top module: `wake_alarm`

## Requirements
- R1: After reset every register reads zero (control, counter, modulo, initial count) and `irq` is low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (counter), 0x08 (modulo) and 0x4C (initial count). Control bits [2:0] hold the prescaler select, bits [4:3] the clock-source select, bit 6 the interrupt enable and bit 7 the overflow flag. All other control bits read 0. The counter, modulo and initial count are 16 bits wide, and their upper read bits are 0.
- R3: Reads of any other offset return zero, and writes to them change no register.
- R4: With clock-source select 2, the counter advances on rising edges of `tick_in`, once per edge however long the input stays high. Any other select value holds the counter.
- R5: A prescaler select of n makes the counter advance once per 2^n tick edges. Selecting 7 divides by 128.
- R6: On each advance the counter increments. If it already equals the modulo value, it loads the initial-count value instead.
- R7: The overflow flag sets on the advance that moves the counter from the modulo value to the initial count.
- R8: A write of any data to the counter offset loads the counter with the current initial count.
- R9: Writing control with bit 7 at 0 clears the overflow flag. Writing bit 7 as 1 leaves the flag unchanged.
- R10: When a flag-setting advance and a flag-clearing write fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly while both the overflow flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Slow fixed-frequency tick, asynchronous |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume that `bus_we` is a clean single-cycle strobe, that the address and data are valid whenever the strobe is high, and that `tick_in` is free of glitches shorter than a bus clock. The bench drives every bus signal on the falling clock edge and keeps `bus_we` low outside write tasks. Each tick pulse is held high for three clocks and low for three, so the synchronizer sees every edge exactly once. The same-cycle set-versus-clear case is built by timing a control write to land on the clock edge at which the synchronized edge reaches the counter.

// File: rtl/wake_alarm.sv
module wake_alarm #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PSW = 3;
  localparam int PDW = (1 << PSW) - 1;
  localparam logic [AW-1:0] OFS_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CNT  = AW'(8'h04);
  localparam logic [AW-1:0] OFS_MOD  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_INIT = AW'(8'h4C);
  localparam logic [1:0]    SRC_TICK = 2'd2;

  logic [PSW-1:0] ps;
  logic [1:0]     cs;
  logic           ie, flag;
  logic [CW-1:0]  cnt, modv, init;
  logic [2:0]     tsync;
  logic [PDW-1:0] pre;

  wire [PDW-1:0] pmask   = ~({PDW{1'b1}} << ps);
  wire           run     = (cs == SRC_TICK);
  wire           rise    = tsync[1] & ~tsync[2];
  wire           pre_top = (pre & pmask) == pmask;
  wire           step    = run & rise & pre_top;
  wire           wrap    = step & (cnt == modv);
  wire           wr_ctrl = bus_we && bus_addr == OFS_CTRL;
  wire           wr_cnt  = bus_we && bus_addr == OFS_CNT;
  wire           wr_mod  = bus_we && bus_addr == OFS_MOD;
  wire           wr_init = bus_we && bus_addr == OFS_INIT;
  logic          unused_bits;

  assign unused_bits = ^{bus_wdata[31:8], bus_wdata[5]};
  assign irq = flag & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) tsync <= '0;
    else        tsync <= {tsync[1:0], tick_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre <= '0;
    else if (rise)      pre <= pre_top ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps <= '0;
      cs <= '0;
      ie <= 1'b0;
    end else if (wr_ctrl) begin
      ps <= bus_wdata[2:0];
      cs <= bus_wdata[4:3];
      ie <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          flag <= 1'b0;
    else if (wrap)                       flag <= 1'b1;
    else if (wr_ctrl && !bus_wdata[7])   flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= init;
    else if (step)   cnt <= wrap ? init : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modv <= '0;
      init <= '0;
    end else begin
      if (wr_mod)  modv <= bus_wdata[CW-1:0];
      if (wr_init) init <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {24'd0, flag, ie, 1'b0, cs, ps};
      OFS_CNT:  bus_rdata = 32'(cnt);
      OFS_MOD:  bus_rdata = 32'(modv);
      OFS_INIT: bus_rdata = 32'(init);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wake_alarm_chk.sv
module wake_alarm_chk #(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [31:0]   bus_wdata,
  input logic          irq,
  input logic [1:0]    cs,
  input logic          flag,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] modv,
  input logic [CW-1:0] init
);
  wire ctrl_wr = bus_we && bus_addr == AW'(8'h00);
  wire cnt_wr  = bus_we && bus_addr == AW'(8'h04);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != 2'd2 && !cnt_wr) |=> $stable(cnt)); // R4
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(init)); // R8
  AST_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == $past(modv) && cnt == $past(init))); // R7
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ctrl_wr && bus_wdata[7]) |=> flag); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq); // R11
endmodule

bind wake_alarm wake_alarm_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq(irq), .cs(cs), .flag(flag),
  .cnt(cnt), .modv(modv), .init(init)
);

// File: tb/wake_alarm_test.sv
module wake_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    bit          is_irq;
    string       req;
  } item_t;
  item_t q[$];
  event  samp;

  localparam logic [7:0] CTRL = 8'h00, CNT = 8'h04, MODR = 8'h08, INIT = 8'h4C;

  always #5 clk = ~clk;

  wake_alarm uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial begin
    forever begin
      @(samp);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'd0, irq} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s addr %h actual %h expected %h", it.req, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    bus_addr = a;
    q.push_back('{a, e, 1'b0, r});
    -> samp;
    #2;
  endtask

  task automatic chk_irq(input logic e, input string r);
    @(negedge clk);
    q.push_back('{8'hFF, {31'd0, e}, 1'b1, r});
    -> samp;
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      repeat (3) @(negedge clk);
      tick_in = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_rd(CTRL, 0, "R1 ctrl reset");
    chk_rd(CNT, 0, "R1 cnt reset");
    chk_rd(MODR, 0, "R1 mod reset");
    chk_rd(INIT, 0, "R1 init reset");
    chk_irq(1'b0, "R1 irq reset");
    chk_rd(8'h10, 0, "R3 unmapped read");

    wr(MODR, 32'd3);
    wr(CTRL, 32'h50);
    chk_rd(CTRL, 32'h50, "R2 ctrl fields");
    wr(CNT, 32'hFFFF);
    chk_rd(CNT, 0, "R8 cnt write loads init 0");
    tick(3);
    chk_rd(CNT, 3, "R4 R6 counts to modulo");
    chk_rd(CTRL, 32'h50, "R7 no flag before reload");
    tick(1);
    chk_rd(CNT, 0, "R6 reload to init");
    chk_rd(CTRL, 32'hD0, "R7 flag on reload");
    chk_irq(1'b1, "R11 irq with flag and enable");
    wr(CTRL, 32'hD0);
    chk_rd(CTRL, 32'hD0, "R9 write one keeps flag");
    chk_irq(1'b1, "R11 irq kept");
    wr(CTRL, 32'h50);
    chk_rd(CTRL, 32'h50, "R9 write zero clears flag");
    chk_irq(1'b0, "R11 irq drops");

    wr(INIT, 32'hFFFF0005);
    chk_rd(INIT, 32'd5, "R2 init 16 bits");
    wr(CNT, 32'h1234);
    chk_rd(CNT, 32'd5, "R8 cnt write ignores data");
    wr(MODR, 32'd6);
    tick(1);
    chk_rd(CNT, 32'd6, "R6 increment from init");
    tick(1);
    chk_rd(CNT, 32'd5, "R6 reload nonzero init");
    chk_rd(CTRL, 32'hD0, "R7 flag nonzero init");

    wr(CTRL, 32'h40);
    chk_rd(CTRL, 32'h40, "R9 clear with source off");
    tick(1);
    chk_rd(CNT, 32'd5, "R4 select 0 holds");
    wr(CTRL, 32'h08);
    tick(1);
    chk_rd(CNT, 32'd5, "R4 select 1 holds");

    wr(CTRL, 32'h52);
    tick(3);
    chk_rd(CNT, 32'd5, "R5 divide 4 before step");
    tick(1);
    chk_rd(CNT, 32'd6, "R5 divide 4 step");
    tick(4);
    chk_irq(1'b1, "R11 irq after divided wrap");

    wr(CTRL, 32'h17);
    chk_irq(1'b0, "R11 irq cleared");
    tick(127);
    chk_rd(CNT, 32'd5, "R5 divide 128 before step");
    tick(1);
    chk_rd(CNT, 32'd6, "R5 divide 128 step");
    tick(128);
    chk_rd(CTRL, 32'h97, "R7 flag with enable off");
    chk_irq(1'b0, "R11 enable off masks irq");

    wr(CTRL, 32'h10);
    wr(MODR, 32'd5);
    tick(1);
    chk_rd(CTRL, 32'h90, "R7 flag at cnt equal mod");
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = CTRL; bus_wdata = 32'h10; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_in = 1'b0;
    repeat (3) @(negedge clk);
    chk_rd(CTRL, 32'h90, "R10 set beats clear");
    wr(CTRL, 32'h10);
    chk_rd(CTRL, 32'h10, "R9 clear after race");

    wr(8'h20, 32'hFFFFFFFF);
    chk_rd(8'h20, 0, "R3 unmapped write then read");
    chk_rd(CTRL, 32'h10, "R3 unmapped write no effect");
    chk_rd(MODR, 32'd5, "R3 modulo untouched");
    wr(MODR, 32'hFFFFABCD);
    chk_rd(MODR, 32'h0000ABCD, "R2 modulo 16 bits");

    repeat (3) @(negedge clk);
    ended = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule